// File: doc/BRIEF.md
# Deferred Interrupt Enable Controller

This block holds a small processor's master interrupt-enable state and decides, at each instruction boundary, whether a device request may be accepted. The execute stage presents decoded I/O function codes. The core strobes the block once per retired instruction, and the console start key arrives as a raw level. The block asks the core to skip the next instruction, asks it to enter the service routine, and drives an indicator lamp showing whether interrupts are on. Saving the program counter and jumping to the handler are done by the core when it sees the take request.

The enable operation is deliberately late. After the enabling instruction retires, one more instruction must retire before interrupts become live, so a return sequence can finish first. The skip-and-disable operation and the plain disable operation both act on the very next clock. Device requests come from a printer output-ready flag and a keyboard input-ready flag. These are merged by a parameterised OR tree.

All control pins are plain levels or one-cycle strobes. No data stream crosses this block, so it has no valid/ready handshake. Every output is a register.

Top module: `intr_gate`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the enable flag, any deferred enable, the skip request and the take pulse. Instruction strobes after reset do not turn interrupts on by themselves.
- R2: An I/O operation with `op_code` 0 pulses `skip_next` high on the edge after the operation cycle, but only if `ion` was high in that cycle. On that same edge `ion` goes low.
- R3: An I/O operation with `op_code` 1 turns `ion` on only at the edge of the second `instr_done` strobe. The first strobe counts even if it arrives in the same cycle as the operation. The strobe that turns `ion` on cannot itself cause a take.
- R4: An I/O operation with `op_code` 2 drives `ion` low on the next edge and cancels any deferred enable from code 1.
- R5: A rising edge of `start_key` clears `ion` and any deferred enable on the next edge. Holding the key high has no further effect.
- R6: When `instr_done` is high, `ion` is high and `tto_flag` or `kbd_flag` is high, `irq_take` is high for exactly the next cycle. `ion` goes low on the same edge.
- R7: No take happens without `instr_done`, while `ion` is low, or while both request flags are low.
- R8: An I/O operation with `op_code` 3 to 7 changes neither `ion`, `skip_next` nor a deferred enable.
- R9: Code 0 leaves a deferred enable from code 1 in place, so it still takes effect on its due strobe.
- R10: When a disable (code 0 or 2), a start-key edge or a take coincides with the strobe that would apply a deferred enable, the disable wins and `ion` ends low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An interrupt-control I/O operation is in execute this cycle |
| op_code | input | 3 | Function digit of that operation: 0 skip-if-on and disable, 1 deferred enable, 2 disable and cancel, 3 to 7 no effect |
| instr_done | input | 1 | One-cycle strobe: an instruction retired |
| start_key | input | 1 | Console start key level |
| tto_flag | input | 1 | Printer output-ready request |
| kbd_flag | input | 1 | Keyboard input-ready request |
| skip_next | output | 1 | One-cycle request to skip the next instruction |
| irq_take | output | 1 | One-cycle request to enter the interrupt handler |
| ion | output | 1 | Interrupt-enable indicator |

## Verification
Every result appears one clock after the cycle that causes it, because `skip_next`, `irq_take` and `ion` are all registers. The bench drives inputs on the falling edge and advances its model on the rising edge. It compares all three outputs one time unit after that edge, so every check reads the value caused by the inputs of the cycle just ended. A deferred enable is traced through two separate strobes. The bench places these strobes in separate, adjacent and coinciding cycles relative to the operation, so the one-instruction delay is checked edge by edge.

// File: rtl/intr_gate_pkg.sv
package intr_gate_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OPC_SKIP_OFF   = 3'd0;
  localparam logic [OP_W-1:0] OPC_ON_LATE    = 3'd1;
  localparam logic [OP_W-1:0] OPC_OFF_CANCEL = 3'd2;
  localparam int SRC_CNT = 2;
endpackage

// File: rtl/intr_key_edge.sv
module intr_key_edge (
  input  logic clk,
  input  logic rst,
  input  logic key_lvl,
  output logic key_rise
);
  logic key_prev;

  always_ff @(posedge clk) begin
    if (rst) key_prev <= 1'b0;
    else     key_prev <= key_lvl;
  end

  assign key_rise = key_lvl & ~key_prev;

  AST_HELD_KEY_QUIET: assert property (@(posedge clk) disable iff (rst)
    key_rise |=> !key_rise); // R5
endmodule

// File: rtl/intr_req_merge.sv
module intr_req_merge #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic         any_req
);
  logic [N:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_or
    assign chain[g+1] = chain[g] | req[g];
  end
  assign any_req = chain[N];
endmodule

// File: rtl/intr_take_ctl.sv
module intr_take_ctl (
  input  logic clk,
  input  logic rst,
  input  logic instr_done,
  input  logic ion_q,
  input  logic any_req,
  output logic take_now,
  output logic take_q
);
  assign take_now = instr_done & ion_q & any_req;

  always_ff @(posedge clk) begin
    if (rst) take_q <= 1'b0;
    else     take_q <= take_now;
  end

  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    take_q |=> !take_q); // R6
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    take_q |-> $past(instr_done) && $past(ion_q)); // R7
  AST_TAKE_DROPS_ION: assert property (@(posedge clk) disable iff (rst)
    take_q |-> !ion_q); // R6
endmodule

// File: rtl/intr_enable_seq.sv
module intr_enable_seq
  import intr_gate_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  input  logic            instr_done,
  input  logic            start_rise,
  input  logic            take_now,
  output logic            ion_q,
  output logic            skip_q
);
  logic armed_q;
  logic due_q;
  logic op_skip;
  logic op_late;
  logic op_cancel;
  logic kill_ion;
  logic kill_defer;
  logic armed_set;

  assign op_skip    = op_valid && (op_code == OPC_SKIP_OFF);
  assign op_late    = op_valid && (op_code == OPC_ON_LATE);
  assign op_cancel  = op_valid && (op_code == OPC_OFF_CANCEL);
  assign kill_ion   = start_rise | op_skip | op_cancel | take_now;
  assign kill_defer = start_rise | op_cancel;
  assign armed_set  = armed_q | op_late;

  always_ff @(posedge clk) begin
    if (rst) begin
      ion_q   <= 1'b0;
      armed_q <= 1'b0;
      due_q   <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      skip_q <= op_skip & ion_q;
      if (kill_ion)                ion_q <= 1'b0;
      else if (instr_done && due_q) ion_q <= 1'b1;
      if (kill_defer) begin
        armed_q <= 1'b0;
        due_q   <= 1'b0;
      end else if (instr_done) begin
        armed_q <= 1'b0;
        due_q   <= armed_set;
      end else begin
        armed_q <= armed_set;
      end
    end
  end

  AST_SKIP_NEEDS_ION: assert property (@(posedge clk) disable iff (rst)
    skip_q |-> $past(ion_q)); // R2
  AST_SKIP_OFF_NOW: assert property (@(posedge clk) disable iff (rst)
    op_skip |=> !ion_q); // R2
  AST_LATE_ON_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(ion_q) |-> $past(instr_done)); // R3
  AST_CANCEL_OFF_NOW: assert property (@(posedge clk) disable iff (rst)
    op_cancel |=> !ion_q && !armed_q && !due_q); // R4
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_rise |=> !ion_q && !due_q); // R5
endmodule

// File: rtl/intr_gate.sv
module intr_gate
  import intr_gate_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  input  logic            instr_done,
  input  logic            start_key,
  input  logic            tto_flag,
  input  logic            kbd_flag,
  output logic            skip_next,
  output logic            irq_take,
  output logic            ion
);
  logic                start_rise;
  logic                any_req;
  logic                take_now;
  logic                ion_q;
  logic                skip_q;
  logic                take_q;
  logic [SRC_CNT-1:0]  req_vec;

  assign req_vec = {kbd_flag, tto_flag};

  intr_key_edge u_key (
    .clk(clk), .rst(rst), .key_lvl(start_key), .key_rise(start_rise)
  );

  intr_req_merge #(.N(SRC_CNT)) u_merge (
    .req(req_vec), .any_req(any_req)
  );

  intr_take_ctl u_take (
    .clk(clk), .rst(rst), .instr_done(instr_done), .ion_q(ion_q),
    .any_req(any_req), .take_now(take_now), .take_q(take_q)
  );

  intr_enable_seq u_seq (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .instr_done(instr_done), .start_rise(start_rise), .take_now(take_now),
    .ion_q(ion_q), .skip_q(skip_q)
  );

  assign skip_next = skip_q;
  assign irq_take  = take_q;
  assign ion       = ion_q;

  AST_NO_SKIP_AND_TAKE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(instr_done)) |-> !irq_take); // R7
endmodule

// File: tb/intr_gate_bench.sv
module intr_gate_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic       instr_done = 1'b0;
  logic       start_key = 1'b0;
  logic       tto_flag = 1'b0;
  logic       kbd_flag = 1'b0;
  logic       skip_next, irq_take, ion;

  int checks = 0;
  int fails  = 0;

  // bench model state, derived from the requirements
  logic m_ion, m_arm, m_due, m_skip, m_take, m_kprev;

  always #5 clk = ~clk;

  intr_gate u_intr_gate (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .instr_done(instr_done), .start_key(start_key), .tto_flag(tto_flag),
    .kbd_flag(kbd_flag), .skip_next(skip_next), .irq_take(irq_take), .ion(ion)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung, expected finish");
    finish_run();
  end

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ion = 0; m_arm = 0; m_due = 0; m_skip = 0; m_take = 0; m_kprev = 0;
  endtask

  task automatic model_step();
    logic rise, skip_op, cancel_op, take, arm_set, kill;
    rise      = start_key && !m_kprev;
    skip_op   = op_valid && op_code == 3'd0;
    cancel_op = op_valid && op_code == 3'd2;
    take      = instr_done && m_ion && (tto_flag || kbd_flag);
    arm_set   = m_arm || (op_valid && op_code == 3'd1);
    kill      = rise || skip_op || cancel_op || take;
    m_skip    = skip_op && m_ion;
    m_take    = take;
    if (kill) m_ion = 0;
    else if (instr_done && m_due) m_ion = 1;
    if (rise || cancel_op) begin m_arm = 0; m_due = 0; end
    else if (instr_done) begin m_due = arm_set; m_arm = 0; end
    else m_arm = arm_set;
    m_kprev = start_key;
  endtask

  task automatic cyc(input logic v, input logic [2:0] c, input logic d,
                     input logic k, input logic t, input logic kb, input string tag);
    @(negedge clk);
    op_valid = v; op_code = c; instr_done = d; start_key = k;
    tto_flag = t; kbd_flag = kb;
    @(posedge clk);
    model_step();
    #1;
    chk(tag, "ion", ion, m_ion);
    chk(tag, "skip_next", skip_next, m_skip);
    chk(tag, "irq_take", irq_take, m_take);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic turn_on();
    cyc(1, 3'd1, 1, 0, 0, 0, "R3");
    cyc(0, 0, 1, 0, 0, 0, "R3");
    chk("R3", "ion after second strobe", ion, 1'b1);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R1", "ion reset", ion, 1'b0);
    chk("R1", "skip reset", skip_next, 1'b0);
    chk("R1", "take reset", irq_take, 1'b0);
    // R1: strobes alone never enable
    cyc(0, 0, 1, 0, 1, 1, "R1");
    cyc(0, 0, 1, 0, 1, 1, "R1");

    // R3: operation and strobes in separate cycles
    cyc(1, 3'd1, 0, 0, 0, 0, "R3");
    idle("R3");
    cyc(0, 0, 1, 0, 0, 0, "R3");
    chk("R3", "ion after first strobe", ion, 1'b0);
    idle("R3");
    cyc(0, 0, 1, 0, 1, 0, "R3"); // enabling strobe: no take despite request
    chk("R3", "ion on", ion, 1'b1);
    chk("R3", "no take on enabling strobe", irq_take, 1'b0);

    // R6 / R7
    cyc(0, 0, 0, 0, 1, 1, "R7");
    chk("R7", "no take without strobe", irq_take, 1'b0);
    cyc(0, 0, 1, 0, 0, 0, "R7");
    chk("R7", "no take without request", irq_take, 1'b0);
    cyc(0, 0, 1, 0, 0, 1, "R6");
    chk("R6", "take pulse", irq_take, 1'b1);
    chk("R6", "ion cleared with take", ion, 1'b0);
    cyc(0, 0, 1, 0, 0, 1, "R6");
    chk("R6", "take one cycle", irq_take, 1'b0);

    // R2: skip when on, none when off
    turn_on();
    cyc(1, 3'd0, 0, 0, 0, 0, "R2");
    chk("R2", "skip when on", skip_next, 1'b1);
    chk("R2", "ion off", ion, 1'b0);
    cyc(1, 3'd0, 0, 0, 0, 0, "R2");
    chk("R2", "no skip when off", skip_next, 1'b0);

    // R8: codes 3..7 inert
    turn_on();
    for (int c = 3; c < 8; c++) begin
      cyc(1, 3'(c), 0, 0, 0, 0, "R8");
      chk("R8", "ion kept", ion, 1'b1);
    end

    // R4: cancel of deferred enable
    cyc(1, 3'd2, 0, 0, 0, 0, "R4");
    chk("R4", "off now", ion, 1'b0);
    cyc(1, 3'd1, 1, 0, 0, 0, "R4");
    cyc(1, 3'd2, 0, 0, 0, 0, "R4");
    cyc(0, 0, 1, 0, 0, 0, "R4");
    chk("R4", "cancelled enable", ion, 1'b0);

    // R9: code 0 keeps deferred enable
    cyc(1, 3'd1, 1, 0, 0, 0, "R9");
    cyc(1, 3'd0, 0, 0, 0, 0, "R9");
    cyc(0, 0, 1, 0, 0, 0, "R9");
    chk("R9", "deferred survives skip op", ion, 1'b1);

    // R5: start key edge and held level
    cyc(0, 0, 0, 1, 0, 0, "R5");
    chk("R5", "start clears", ion, 1'b0);
    cyc(1, 3'd1, 1, 1, 0, 0, "R5");
    cyc(0, 0, 1, 1, 0, 0, "R5");
    chk("R5", "held key inert", ion, 1'b1);
    idle("R5");

    // R10: disable coinciding with applying strobe
    cyc(1, 3'd1, 1, 0, 0, 0, "R10");
    cyc(1, 3'd2, 1, 0, 0, 0, "R10");
    chk("R10", "cancel wins", ion, 1'b0);
    cyc(1, 3'd1, 1, 0, 0, 0, "R10");
    cyc(1, 3'd0, 1, 0, 0, 0, "R10");
    chk("R10", "skip op wins", ion, 1'b0);

    // random mix
    void'($urandom(32'd4711));
    for (int i = 0; i < 4000; i++) begin
      logic v, d, t, kb, k;
      logic [2:0] c;
      v  = ($urandom % 4) == 0;
      c  = 3'($urandom % 5);
      d  = ($urandom % 3) == 0;
      t  = ($urandom % 5) == 0;
      kb = ($urandom % 5) == 0;
      k  = ($urandom % 60) == 0 ? !start_key : start_key;
      cyc(v, c, d, k, t, kb, "R10");
    end
    finish_run();
  end
endmodule